// File: doc/BRIEF.md
# Serial Byte Memory with Two-Wire Slave Front End

This block is the digital side of a byte-wide serial memory that answers as a slave on an I2C bus. It recovers START and STOP conditions and bit timing from the bus lines after resynchronising them to a faster system clock. It accepts a device-select byte only when the three strap inputs match its address field. It then takes a two-byte memory address and streams data bytes into, or out of, an on-chip synchronous RAM. An address counter steps to the next location after every data byte, so multi-byte transfers cover consecutive locations.

The array holds 2^AW bytes. AW is 14 for the full 16,384 x 8 part; the default is smaller so that elaboration stays light. A write-protect input stops every array write while reads stay fully available. The SDA pad is open-drain, so the block exposes only a pull-low enable. Pull-downs on unconnected strap and protect pins belong to the pad ring and are not part of this block.

Top module: `serial_mem_slave`

## Requirements
- R1: A device-select byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal strapAddr[2:0]; bit 0 is 1 for read and 0 for write. On any mismatch the byte is not acknowledged, and the rest of the transaction (further bytes, ACKs, writes) is ignored until the next START.
- R2: Bus bits are sampled on SCL rising edges, and the block changes its SDA pull-low enable only while SCL is low.
- R3: After a write select, the block acknowledges an address high byte, an address low byte and any number of data bytes. Each data byte is stored at the counter address, and only the low AW bits of the 16-bit address are used.
- R4: With wrProtect high, data bytes are still acknowledged and the counter still advances, but the array is left unchanged.
- R5: Reads return stored data regardless of wrProtect.
- R6: A repeated START followed by a read select, after the address phase, returns data starting at the address just loaded.
- R7: A read select with no address phase returns data from the counter's present value.
- R8: The counter steps by one after every data byte and wraps from 2^AW-1 to 0.
- R9: When the master does not acknowledge a read byte, the block releases SDA and ignores all further SCL pulses until a START.
- R10: After reset and after any STOP, SDA is released. A STOP during the address phase keeps any address already loaded.
- R11: sdaOe high means the block pulls SDA low; the block never drives SDA high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| strapAddr | input | 3 | Board straps selecting the device address |
| wrProtect | input | 1 | High blocks all array writes |
| sdaOe | output | 1 | High pulls the SDA line low |

## Verification
A wrong control state shows first on the SDA pull-down. A missing or extra ACK appears within the ninth SCL pulse of the byte concerned. A misaligned transmit register corrupts the very next byte a master reads. Address-counter faults only surface when data is read back, so every write is followed by a read of the same range, including the wrap from the top location to zero. Protect and select faults leave no mark on the bus during the write itself. They are exposed by reading the targeted locations afterwards and comparing them with a bench model of the array.

// File: rtl/smem_pkg.sv
package smem_pkg;

  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic ldAddrHi;
    logic ldAddrLo;
    logic memWr;
    logic loadTx;
    logic shiftTx;
    logic incAddr;
  } ctrlStb_t;

endpackage

// File: rtl/smem_line_sync.sv
module smem_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);

  localparam int LINES = 2;

  logic [LINES-1:0] lineIn;
  logic [LINES-1:0] lineOut;
  logic [LINES-1:0] lineDly;

  assign lineIn = {sdaIn, sclIn};

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [SYNC_STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[SYNC_STAGES-2:0], lineIn[g]};
      end
      assign lineOut[g] = pipe[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineDly <= '1;
    else       lineDly <= lineOut;
  end

  assign sclS    = lineOut[0];
  assign sdaS    = lineOut[1];
  assign sclRise = lineOut[0] & ~lineDly[0];
  assign sclFall = ~lineOut[0] & lineDly[0];
  assign startEv = lineOut[0] & lineDly[0] & lineDly[1] & ~lineOut[1];
  assign stopEv  = lineOut[0] & lineDly[0] & ~lineDly[1] & lineOut[1];

endmodule

// File: rtl/smem_ctrl.sv
module smem_ctrl
  import smem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       sdaS,
  input  logic [7:0] rxByte,
  input  logic [2:0] straps,
  input  logic       wrProt,
  output ctrlStb_t   stb,
  output logic       ackOe,
  output logic       txActive,
  output busState_t  state
);

  logic [3:0] bitCnt;
  logic       ackPhase;
  logic       masterAck;
  logic       selHit;
  logic       rxState;
  logic       byteDone;
  logic       ackEnd;

  assign selHit   = (rxByte[7:4] == TYPE_CODE) && (rxByte[3:1] == straps);
  assign rxState  = (state == ST_DEV) || (state == ST_AHI) ||
                    (state == ST_ALO) || (state == ST_WR);
  assign byteDone = sclFall && !ackPhase && (bitCnt == 4'd8);
  assign ackEnd   = sclFall && ackPhase;

  always_comb begin
    stb = '0;
    if (!startEv && !stopEv) begin
      if (rxState && sclRise && !ackPhase && (bitCnt < 4'd8))
        stb.shiftIn = 1'b1;
      if (byteDone) begin
        case (state)
          ST_AHI: stb.ldAddrHi = 1'b1;
          ST_ALO: stb.ldAddrLo = 1'b1;
          ST_WR: begin
            stb.memWr   = !wrProt;
            stb.incAddr = 1'b1;
          end
          default: ;
        endcase
      end
      if ((state == ST_RD) && sclFall && !ackPhase &&
          (bitCnt != 4'd0) && (bitCnt < 4'd8))
        stb.shiftTx = 1'b1;
      if (ackEnd && (((state == ST_DEV) && selHit && rxByte[0]) ||
                     ((state == ST_RD) && masterAck))) begin
        stb.loadTx  = 1'b1;
        stb.incAddr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackPhase  <= 1'b0;
      ackOe     <= 1'b0;
      txActive  <= 1'b0;
      masterAck <= 1'b0;
    end else if (startEv || stopEv) begin
      state    <= startEv ? ST_DEV : ST_IDLE;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      ackOe    <= 1'b0;
      txActive <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
          if (sclRise && !ackPhase && (bitCnt < 4'd8)) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            ackPhase <= 1'b1;
            ackOe    <= (state != ST_DEV) || selHit;
          end else if (ackEnd) begin
            ackPhase <= 1'b0;
            ackOe    <= 1'b0;
            bitCnt   <= '0;
            case (state)
              ST_DEV: begin
                if (!selHit) begin
                  state <= ST_IDLE;
                end else if (rxByte[0]) begin
                  state    <= ST_RD;
                  txActive <= 1'b1;
                end else begin
                  state <= ST_AHI;
                end
              end
              ST_AHI:  state <= ST_ALO;
              ST_ALO:  state <= ST_WR;
              default: state <= ST_WR;
            endcase
          end
        end
        ST_RD: begin
          if (sclRise && !ackPhase && (bitCnt < 4'd8)) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            ackPhase <= 1'b1;
            txActive <= 1'b0;
          end else if (sclRise && ackPhase) begin
            masterAck <= !sdaS;
          end else if (ackEnd) begin
            ackPhase <= 1'b0;
            bitCnt   <= '0;
            if (masterAck) txActive <= 1'b1;
            else           state    <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/smem_dpath.sv
module smem_dpath
  import smem_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStb_t   stb,
  input  logic       sdaS,
  output logic [7:0] rxByte,
  output logic       txBit
);

  localparam int DEPTH = 1 << AW;

  logic [7:0]    rxSh;
  logic [7:0]    txSh;
  logic [7:0]    rdData;
  logic [AW-1:0] addrCnt;
  logic [AW-1:0] newAddr;
  logic [7:0]    mem [0:DEPTH-1];

  generate
    if (AW > 8) begin : g_hi
      logic [AW-9:0] hiBits;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             hiBits <= '0;
        else if (stb.ldAddrHi) hiBits <= rxSh[AW-9:0];
      end
      assign newAddr = {hiBits, rxSh};
    end else begin : g_nohi
      assign newAddr = rxSh[AW-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh    <= '0;
      txSh    <= '1;
      addrCnt <= '0;
    end else begin
      if (stb.shiftIn)       rxSh <= {rxSh[6:0], sdaS};
      if (stb.loadTx)        txSh <= rdData;
      else if (stb.shiftTx)  txSh <= {txSh[6:0], 1'b1};
      if (stb.ldAddrLo)      addrCnt <= newAddr;
      else if (stb.incAddr)  addrCnt <= addrCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.memWr) mem[addrCnt] <= rxSh;
    rdData <= mem[addrCnt];
  end

  assign rxByte = rxSh;
  assign txBit  = txSh[7];

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import smem_pkg::*;
#(
  parameter int AW          = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  input  logic       wrProtect,
  output logic       sdaOe
);

  logic       sclSync, sdaSync, sclRise, sclFall, startEv, stopEv;
  logic       ackOe, txActive, txBit;
  logic [7:0] rxByte;
  ctrlStb_t   stb;
  busState_t  busState;

  smem_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclSync), .sdaS(sdaSync), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  smem_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaS(sdaSync), .rxByte(rxByte),
    .straps(strapAddr), .wrProt(wrProtect), .stb(stb), .ackOe(ackOe),
    .txActive(txActive), .state(busState)
  );

  smem_dpath #(.AW(AW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaS(sdaSync),
    .rxByte(rxByte), .txBit(txBit)
  );

  assign sdaOe = ackOe | (txActive & ~txBit);

endmodule

// File: rtl/smem_checker.sv
module smem_checker
  import smem_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sclS,
  input logic      stopEv,
  input logic      sdaOe,
  input logic      wrProtect,
  input ctrlStb_t  stb,
  input busState_t busState
);

  assert_wp_no_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrProtect |-> !stb.memWr);

  assert_pull_only_scl_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS);

  assert_stop_releases_R10: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaOe);

  assert_single_action_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shiftIn, stb.ldAddrHi, stb.ldAddrLo, stb.memWr,
              stb.loadTx, stb.shiftTx}));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_IDLE) |-> !sdaOe);

endmodule

bind serial_mem_slave smem_checker u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclSync), .stopEv(stopEv), .sdaOe(sdaOe),
  .wrProtect(wrProtect), .stb(stb), .busState(busState)
);

// File: tb/sim_serial_mem_slave.sv
module sim_serial_mem_slave;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int Q     = 6;
  localparam int H     = 12;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mLow = 1'b0;
  logic wp = 1'b0;
  logic sdaOe;
  wire  sdaBus = !(mLow || sdaOe);

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int r2Viol = 0;
  logic prevScl = 1'b1;
  logic prevOe = 1'b0;
  logic [7:0] model [0:DEPTH-1];

  always #4 clk = ~clk;

  serial_mem_slave #(.AW(AW)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .strapAddr(STRAP), .wrProtect(wp), .sdaOe(sdaOe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2 monitor: the pull-down must not change while SCL stays high
  always @(posedge clk) begin
    cycles++;
    if (rstN && prevScl && scl && (sdaOe != prevOe)) r2Viol++;
    prevScl <= scl;
    prevOe  <= sdaOe;
    if (cycles > 190000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic startC();
    mLow = 1'b0; tick(Q);
    scl = 1'b1;  tick(H);
    mLow = 1'b1; tick(H);
    scl = 1'b0;  tick(Q);
  endtask

  task automatic stopC();
    mLow = 1'b1; tick(Q);
    scl = 1'b1;  tick(H);
    mLow = 1'b0; tick(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mLow = !b[i]; tick(Q);
      scl = 1'b1;   tick(H);
      scl = 1'b0;   tick(Q);
    end
    mLow = 1'b0; tick(Q);
    scl = 1'b1;  tick(H / 2);
    ack = !sdaBus;
    tick(H / 2);
    scl = 1'b0;  tick(Q);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    mLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(H / 2);
      b[i] = sdaBus;
      tick(H / 2);
      scl = 1'b0; tick(Q);
    end
    mLow = ackIt; tick(Q);
    scl = 1'b1;   tick(H);
    scl = 1'b0;   tick(Q);
    mLow = 1'b0;
  endtask

  function automatic logic [7:0] dev(input logic [2:0] s, input logic rw);
    return {4'b1010, s, rw};
  endfunction

  task automatic addrPhase(input logic [15:0] a, input string req);
    logic ack;
    startC();
    sendByte(dev(STRAP, 1'b0), ack); chk({req, " dev-w ack"}, ack, 1);
    sendByte(a[15:8], ack);          chk({req, " addr-hi ack"}, ack, 1);
    sendByte(a[7:0], ack);           chk({req, " addr-lo ack"}, ack, 1);
  endtask

  task automatic readBurst(input int first, input int n, input string req);
    logic ack;
    logic [7:0] b;
    sendByte(dev(STRAP, 1'b1), ack); chk({req, " dev-r ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, b);
      chk({req, " read data"}, b, model[(first + k) % DEPTH]);
    end
    stopC();
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    int lows;
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hxx;
    tick(5);
    chk("R10 reset release", sdaOe, 0);
    rstN = 1'b1;
    tick(5);
    chk("R11 idle bus high", sdaBus, 1);

    // R1: sweep every strap value plus a wrong type code
    for (int s = 0; s < 8; s++) begin
      startC();
      sendByte(dev(3'(s), 1'b0), ack);
      chk("R1 select sweep", ack, (s == STRAP));
      stopC();
    end
    startC();
    sendByte({4'b1011, STRAP, 1'b0}, ack);
    chk("R1 type code mismatch", ack, 0);
    stopC();

    // R3: fill the whole array in one burst
    addrPhase(16'h0000, "R3");
    for (int a = 0; a < DEPTH; a++) begin
      sendByte(pat(a), ack);
      chk("R3 data ack", ack, 1);
      model[a] = pat(a);
    end
    stopC();

    // R6/R8: repeated START read of all locations from 0, then wrap
    addrPhase(16'h0000, "R6");
    startC();
    readBurst(0, DEPTH, "R6");
    addrPhase(16'(DEPTH - 1), "R8");
    startC();
    readBurst(DEPTH - 1, 3, "R8 wrap");

    // R4/R5: writes ignored under protect, counter still steps
    wp = 1'b1;
    addrPhase(16'h0010, "R4");
    sendByte(8'hAA, ack); chk("R4 protected ack", ack, 1);
    sendByte(8'h55, ack); chk("R4 protected ack", ack, 1);
    stopC();
    startC();
    readBurst(16'h12, 1, "R4 counter advanced");
    addrPhase(16'h0010, "R5");
    startC();
    readBurst(16'h10, 2, "R5 read under protect");
    wp = 1'b0;

    // R3: upper address bits dropped
    addrPhase(16'hABC5, "R3 high bits");
    sendByte(8'h99, ack); chk("R3 data ack", ack, 1);
    model[16'hC5 % DEPTH] = 8'h99;
    stopC();
    addrPhase(16'h0005, "R3");
    startC();
    readBurst(5, 1, "R3 truncated address");

    // R1: transaction to another device leaves the array alone
    startC();
    sendByte(dev(3'b000, 1'b0), ack); chk("R1 foreign select", ack, 0);
    sendByte(8'h00, ack);             chk("R1 foreign byte ignored", ack, 0);
    sendByte(8'h05, ack);             chk("R1 foreign byte ignored", ack, 0);
    sendByte(8'h11, ack);             chk("R1 foreign byte ignored", ack, 0);
    stopC();
    addrPhase(16'h0005, "R1");
    startC();
    readBurst(5, 1, "R1 location unchanged");

    // R9: NACK ends the read, later clocks are ignored
    addrPhase(16'h0020, "R9");
    startC();
    sendByte(dev(STRAP, 1'b1), ack); chk("R9 dev-r ack", ack, 1);
    recvByte(1'b0, b);               chk("R9 data", b, model[16'h20]);
    lows = 0;
    for (int k = 0; k < 9; k++) begin
      tick(Q);
      scl = 1'b1; tick(H / 2);
      if (!sdaBus) lows++;
      tick(H / 2);
      scl = 1'b0; tick(Q);
    end
    chk("R9 released after nack", lows, 0);
    stopC();
    chk("R10 released after stop", sdaBus, 1);

    // R7: current address read continues at 0x21
    startC();
    readBurst(16'h21, 2, "R7 current address");

    // R10: STOP after the address phase keeps the loaded address
    addrPhase(16'h0007, "R10");
    stopC();
    startC();
    readBurst(7, 1, "R10 address kept");

    chk("R2 no change while SCL high", r2Viol, 0);
    chk("R11 released at end", sdaOe, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule